// File: doc/BRIEF.md
# PLL Lock Detector with Monitor Pin Multiplexer

This block watches the two divided pulse trains that a frequency synthesizer compares: the reference-side pulse and the VCO-side pulse. Each pulse is one reference-clock cycle wide and synchronous to that clock. For every pairing of one reference pulse with one VCO pulse, the block measures how many reference clocks separate them. It declares the loop locked only after a run of close pairings. It also clears that decision the moment one pairing is too far apart.

The lock decision reaches a single monitor pin through a 3-bit select. The same pin can carry other signals for bring-up: a halved copy of either pulse train, the raw reference pulse, or the outcome of the most recent pairing. A second output can carry the reference clock divided by eight. Pins that would be tri-stated are represented by output-enable flags, one for the charge-pump output and one for the buffer output. A standby input parks the whole block. In standby the monitor pin is held high and both enables are dropped.

Top module: `ld_mon_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), with select 100 and standby low, ld_pin is low until a lock is earned.
- R2: A comparison pairs one fr_pulse with one fv_pulse, whichever comes first, and measures the number of clock edges between them. Both pulses on the same edge give a gap of 0. The comparison passes when the gap is 0 or 1. An edge that closes one comparison and also carries a second pulse of the opener's kind starts the next comparison, and both comparisons are counted.
- R3: With select 100, ld_pin rises just after the edge of the fourth consecutive passing comparison (more than three). After three passes it is still low.
- R4: A failing comparison clears the run and drops the lock state on the edge at which it is judged. A comparison fails when its gap is 2 or more, or when a second pulse of the same kind arrives before the partner pulse. A new lock then needs four fresh passes.
- R5: While standby is high, ld_pin is high whatever the select, and pulses are ignored. Standby also clears the pass run, the lock state, both halving flip-flops and the divide-by-eight counter.
- R6: Select 001 puts the fR/2 flip-flop on ld_pin, and select 101 puts the fv/2 flip-flop on it. Each flip-flop toggles on every pulse of its train outside standby and starts at 0.
- R7: Select 000 drives ld_pin low. Select 010 drives it with the fr_pulse registered one edge. Select 011 drives it low. Select 110 drives it with the result of the most recent comparison (1 = passed). Select 111 drives it with the lock state, as select 100 does.
- R8: A 3-bit counter of clock edges is cleared in reset and in standby. buf_oe is high only for selects 011 and 111 outside standby. buf_pin equals the counter MSB when buf_oe is high and is 0 otherwise.
- R9: cp_oe is low for selects 001, 010, 101 and 110, and while standby is high. It is high in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Parks the block: clears state, forces ld_pin high, drops enables |
| fr_pulse | input | 1 | One-cycle reference-divider output pulse |
| fv_pulse | input | 1 | One-cycle input-divider output pulse |
| ld_sel | input | 3 | Monitor select, bit 2 is the MSB of the codes in R3 and R6 to R9 |
| ld_pin | output | 1 | Monitor pin: lock state or a selected test signal |
| cp_oe | output | 1 | Charge-pump output enable (low means high impedance) |
| buf_pin | output | 1 | Buffer output carrying the reference clock divided by eight |
| buf_oe | output | 1 | Buffer output enable (low means high impedance) |

## Verification
Closing one comparison and opening the next can fall on the same clock edge. This happens when a pulse of the waiting kind and a pulse of the partner kind arrive together while a comparison is open. The bench provokes it with the sequence reference, then both, then VCO, on three consecutive edges. It ends that run with a simultaneous pair that would be the fourth pass only if both overlapping comparisons were counted. ld_pin must therefore rise exactly at that fourth pass; a design that drops either comparison leaves it low, and the scoreboard reports a mismatch.

// File: rtl/ld_mon_pkg.sv
`timescale 1ns/1ps
// Package: shared select encoding and helper decodes for the lock monitor.
// Assumes the select field is presented MSB first as bit 2.
package ld_mon_pkg;

    // Monitor pin sources selected by the 3-bit field
    typedef enum logic [2:0] {
        SEL_FORCE_LOW = 3'b000,
        SEL_REF_HALF  = 3'b001,
        SEL_REF_PULSE = 3'b010,
        SEL_REF8_LOW  = 3'b011,
        SEL_LOCK      = 3'b100,
        SEL_VCO_HALF  = 3'b101,
        SEL_LAST_CMP  = 3'b110,
        SEL_LOCK_REF8 = 3'b111
    } ld_sel_e;

    // Codes that float the charge-pump output
    function automatic logic cp_floats(input logic [2:0] s);
        return (s == 3'b001) || (s == 3'b010) || (s == 3'b101) || (s == 3'b110);
    endfunction

    // Codes that route the divided reference onto the buffer output
    function automatic logic buf_drives(input logic [2:0] s);
        return (s[1:0] == 2'b11);
    endfunction

endpackage

// File: rtl/ld_phase_meter.sv
`timescale 1ns/1ps
// Module: ld_phase_meter
// Pairs each reference pulse with each VCO pulse and measures the gap in
// clock edges between them. Emits a one-cycle comparison strobe and a pass
// flag (gap below WIN) combinationally on the edge that closes a pairing.
// Assumes both pulses are single-cycle and synchronous to clk, WIN >= 1.
module ld_phase_meter #(
    parameter int WIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic fr_pulse,
    input  logic fv_pulse,
    output logic cmp_valid,
    output logic cmp_pass
);
    localparam int DIST_W = $clog2(WIN + 1) + 1;
    localparam logic [DIST_W-1:0] WIN_D = DIST_W'(WIN);
    localparam logic [DIST_W-1:0] ONE_D = DIST_W'(1);

    logic              open_q, open_d;
    logic              open_fr_q, open_fr_d;
    logic [DIST_W-1:0] gap_q, gap_d;
    logic              partner, again;

    // Purpose: decide next pairing state and the comparison outcome
    always_comb begin
        open_d    = open_q;
        open_fr_d = open_fr_q;
        gap_d     = gap_q;
        cmp_valid = 1'b0;
        cmp_pass  = 1'b0;
        partner   = open_fr_q ? fv_pulse : fr_pulse;
        again     = open_fr_q ? fr_pulse : fv_pulse;
        if (standby) begin
            open_d = 1'b0;
            gap_d  = '0;
        end else if (!open_q) begin
            if (fr_pulse && fv_pulse) begin
                cmp_valid = 1'b1;
                cmp_pass  = 1'b1;
            end else if (fr_pulse || fv_pulse) begin
                open_d    = 1'b1;
                open_fr_d = fr_pulse;
                gap_d     = ONE_D;
            end
        end else if (partner) begin
            cmp_valid = 1'b1;
            cmp_pass  = (gap_q < WIN_D);
            if (again) begin
                gap_d = ONE_D;
            end else begin
                open_d = 1'b0;
            end
        end else if (again) begin
            cmp_valid = 1'b1;
            cmp_pass  = 1'b0;
            gap_d     = ONE_D;
        end else if (gap_q < WIN_D) begin
            gap_d = gap_q + ONE_D;
        end
    end

    // Purpose: hold the open pairing and its saturating gap count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            open_fr_q <= 1'b0;
            gap_q     <= '0;
        end else begin
            open_q    <= open_d;
            open_fr_q <= open_fr_d;
            gap_q     <= gap_d;
        end
    end

endmodule

// File: rtl/ld_lock_qualifier.sv
`timescale 1ns/1ps
// Module: ld_lock_qualifier
// Counts consecutive passing comparisons and declares lock once the run
// exceeds LOCK_RUNS. Any failing comparison clears the run and the lock.
// Also keeps the result of the most recent comparison for test output.
// Assumes cmp_valid is already masked in standby.
module ld_lock_qualifier #(
    parameter int LOCK_RUNS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic cmp_valid,
    input  logic cmp_pass,
    output logic locked,
    output logic last_pass
);
    localparam int CNT_W = $clog2(LOCK_RUNS + 2);
    localparam logic [CNT_W-1:0] RUNS_D = CNT_W'(LOCK_RUNS);
    localparam logic [CNT_W-1:0] FULL_D = CNT_W'(LOCK_RUNS + 1);

    logic [CNT_W-1:0] run_q;

    // Purpose: update the pass run, the lock flag and the last result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            locked    <= 1'b0;
            last_pass <= 1'b0;
        end else if (standby) begin
            run_q     <= '0;
            locked    <= 1'b0;
            last_pass <= 1'b0;
        end else if (cmp_valid) begin
            last_pass <= cmp_pass;
            if (cmp_pass) begin
                if (run_q != FULL_D) begin
                    run_q <= run_q + CNT_W'(1);
                end
                locked <= (run_q >= RUNS_D);
            end else begin
                run_q  <= '0;
                locked <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ld_div_monitor.sv
`timescale 1ns/1ps
// Module: ld_div_monitor
// Produces the test-side signals: halved copies of both pulse trains, a
// registered copy of the reference pulse, and the MSB of a free-running
// power-of-two divider of the clock. Everything clears in standby.
module ld_div_monitor #(
    parameter int REF_DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic fr_pulse,
    input  logic fv_pulse,
    output logic fr_half,
    output logic fv_half,
    output logic fr_seen,
    output logic ref_tap
);
    logic [REF_DIV_LOG2-1:0] ref_cnt;

    // Purpose: toggle the halving flip-flops and register the reference pulse
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            fr_half <= 1'b0;
            fv_half <= 1'b0;
            fr_seen <= 1'b0;
        end else begin
            fr_half <= fr_half ^ fr_pulse;
            fv_half <= fv_half ^ fv_pulse;
            fr_seen <= fr_pulse;
        end
    end

    // Purpose: count clock edges for the divided reference output
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ref_cnt <= '0;
        end else begin
            ref_cnt <= ref_cnt + REF_DIV_LOG2'(1);
        end
    end

    assign ref_tap = ref_cnt[REF_DIV_LOG2-1];

endmodule

// File: rtl/ld_pin_mux.sv
`timescale 1ns/1ps
// Module: ld_pin_mux
// Combinational selection of the monitor pin source plus the two output
// enables. Standby overrides the select: pin high, enables low.
module ld_pin_mux
    import ld_mon_pkg::*;
(
    input  logic [2:0] ld_sel,
    input  logic       standby,
    input  logic       locked,
    input  logic       last_pass,
    input  logic       fr_half,
    input  logic       fv_half,
    input  logic       fr_seen,
    input  logic       ref_tap,
    output logic       ld_pin,
    output logic       cp_oe,
    output logic       buf_pin,
    output logic       buf_oe
);
    ld_sel_e sel_e;
    assign sel_e = ld_sel_e'(ld_sel);

    // Purpose: pick the monitor pin source
    always_comb begin
        ld_pin = 1'b0;
        if (standby) begin
            ld_pin = 1'b1;
        end else begin
            case (sel_e)
                SEL_FORCE_LOW: ld_pin = 1'b0;
                SEL_REF_HALF:  ld_pin = fr_half;
                SEL_REF_PULSE: ld_pin = fr_seen;
                SEL_REF8_LOW:  ld_pin = 1'b0;
                SEL_LOCK:      ld_pin = locked;
                SEL_VCO_HALF:  ld_pin = fv_half;
                SEL_LAST_CMP:  ld_pin = last_pass;
                SEL_LOCK_REF8: ld_pin = locked;
                default:       ld_pin = 1'b0;
            endcase
        end
    end

    // Purpose: derive output enables and the gated buffer output
    always_comb begin
        cp_oe   = !standby && !cp_floats(ld_sel);
        buf_oe  = !standby && buf_drives(ld_sel);
        buf_pin = buf_oe && ref_tap;
    end

endmodule

// File: rtl/ld_mon_top.sv
`timescale 1ns/1ps
// Module: ld_mon_top
// Lock detector and monitor multiplexer for a synthesizer loop. Pairs the
// divider pulses, qualifies lock over a run of close pairings and routes
// the result or a test signal to the monitor pin.
// Assumes pulses are one clock wide and synchronous to clk.
module ld_mon_top #(
    parameter int WIN          = 2,
    parameter int LOCK_RUNS    = 3,
    parameter int REF_DIV_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       fr_pulse,
    input  logic       fv_pulse,
    input  logic [2:0] ld_sel,
    output logic       ld_pin,
    output logic       cp_oe,
    output logic       buf_pin,
    output logic       buf_oe
);
    logic cmp_valid, cmp_pass;
    logic locked, last_pass;
    logic fr_half, fv_half, fr_seen, ref_tap;

    ld_phase_meter #(.WIN(WIN)) meter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .fr_pulse  (fr_pulse),
        .fv_pulse  (fv_pulse),
        .cmp_valid (cmp_valid),
        .cmp_pass  (cmp_pass)
    );

    ld_lock_qualifier #(.LOCK_RUNS(LOCK_RUNS)) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .cmp_valid (cmp_valid),
        .cmp_pass  (cmp_pass),
        .locked    (locked),
        .last_pass (last_pass)
    );

    ld_div_monitor #(.REF_DIV_LOG2(REF_DIV_LOG2)) divs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .fr_pulse (fr_pulse),
        .fv_pulse (fv_pulse),
        .fr_half  (fr_half),
        .fv_half  (fv_half),
        .fr_seen  (fr_seen),
        .ref_tap  (ref_tap)
    );

    ld_pin_mux mux_i (
        .ld_sel    (ld_sel),
        .standby   (standby),
        .locked    (locked),
        .last_pass (last_pass),
        .fr_half   (fr_half),
        .fv_half   (fv_half),
        .fr_seen   (fr_seen),
        .ref_tap   (ref_tap),
        .ld_pin    (ld_pin),
        .cp_oe     (cp_oe),
        .buf_pin   (buf_pin),
        .buf_oe    (buf_oe)
    );

endmodule

// File: rtl/ld_mon_checker.sv
`timescale 1ns/1ps
// Module: ld_mon_checker
// Temporal checks on the lock monitor, attached to the top by bind.
module ld_mon_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       standby,
    input logic       fr_pulse,
    input logic [2:0] ld_sel,
    input logic       ld_pin,
    input logic       cp_oe,
    input logic       buf_oe,
    input logic       cmp_valid,
    input logic       cmp_pass,
    input logic       locked,
    input logic       fr_half
);
    // R5: standby holds the monitor pin high
    assert_standby_pin_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> ld_pin);

    // R9: standby floats both outputs
    assert_standby_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!cp_oe && !buf_oe));

    // R4: a failing comparison leaves no lock behind
    assert_fail_unlocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_pass && !standby) |=> !locked);

    // R3: lock only appears right after a passing comparison
    assert_lock_after_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmp_valid && cmp_pass));

    // R7: select 000 forces the pin low
    assert_force_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && ld_sel == 3'b000) |-> !ld_pin);

    // R6: each reference pulse flips the halving flip-flop
    assert_ref_half_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_pulse && !standby) |=> (fr_half != $past(fr_half)));

    // R8: the buffer is enabled only for its two codes
    assert_buf_enable_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_oe |-> (!standby && ld_sel[1:0] == 2'b11));

endmodule

bind ld_mon_top ld_mon_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .fr_pulse  (fr_pulse),
    .ld_sel    (ld_sel),
    .ld_pin    (ld_pin),
    .cp_oe     (cp_oe),
    .buf_oe    (buf_oe),
    .cmp_valid (cmp_valid),
    .cmp_pass  (cmp_pass),
    .locked    (locked),
    .fr_half   (fr_half)
);

// File: tb/ld_mon_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected record per cycle, the
// monitor pops it at the falling edge and compares all four outputs.
module ld_mon_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       fr_pulse = 1'b0;
    logic       fv_pulse = 1'b0;
    logic [2:0] ld_sel = 3'b100;
    logic       ld_pin, cp_oe, buf_pin, buf_oe;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic  ld;
        logic  cp;
        logic  boe;
        logic  bpin;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic [2:0] ref_m = 3'd0;

    always #5 clk = ~clk;

    ld_mon_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .fr_pulse (fr_pulse),
        .fv_pulse (fv_pulse),
        .ld_sel   (ld_sel),
        .ld_pin   (ld_pin),
        .cp_oe    (cp_oe),
        .buf_pin  (buf_pin),
        .buf_oe   (buf_oe)
    );

    // Expected divide-by-eight counter, per R8
    always @(posedge clk) begin
        if (!rst_n || standby) ref_m <= 3'd0;
        else ref_m <= ref_m + 3'd1;
    end

    task automatic chk(input logic act, input logic exp, input string what, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // Monitor: compare outputs against the oldest expected record
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(ld_pin,  e.ld,   "ld_pin",     e.tag);
            chk(cp_oe,   e.cp,   "cp_oe R9",   e.tag);
            chk(buf_oe,  e.boe,  "buf_oe R8",  e.tag);
            chk(buf_pin, e.bpin, "buf_pin R8", e.tag);
        end
    end

    // Driver: one clock cycle of stimulus plus its expected outputs
    task automatic step(input logic f_r, input logic f_v, input logic sb,
                        input logic [2:0] sel, input logic e_ld, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        fr_pulse = f_r;
        fv_pulse = f_v;
        standby  = sb;
        ld_sel   = sel;
        @(posedge clk);
        #1;
        e.ld   = e_ld;
        e.cp   = !sb && !(sel == 3'b001 || sel == 3'b010 || sel == 3'b101 || sel == 3'b110);
        e.boe  = !sb && (sel[1:0] == 2'b11);
        e.bpin = e.boe && ref_m[2];
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 3'b100, 0, "R1 reset leaves lock clear");
        step(1, 1, 0, 3'b100, 0, "R3 one pass");
        step(0, 0, 0, 3'b100, 0, "R3 idle");
        step(1, 1, 0, 3'b100, 0, "R3 two passes");
        step(1, 1, 0, 3'b100, 0, "R3 three passes not enough");
        step(1, 1, 0, 3'b100, 1, "R3 fourth pass locks");
        step(1, 0, 0, 3'b100, 1, "R2 open pairing");
        step(0, 1, 0, 3'b100, 1, "R2 gap of one passes");
        step(1, 0, 0, 3'b100, 1, "R4 open pairing");
        step(0, 0, 0, 3'b100, 1, "R4 waiting");
        step(0, 1, 0, 3'b100, 0, "R4 gap of two unlocks");
        step(1, 1, 0, 3'b100, 0, "R4 relock pass one");
        step(1, 1, 0, 3'b100, 0, "R4 relock pass two");
        step(1, 1, 0, 3'b100, 0, "R4 run restarted after three");
        step(1, 1, 0, 3'b100, 1, "R4 relock on fourth");
        step(0, 1, 0, 3'b100, 1, "R4 vco opens pairing");
        step(0, 1, 0, 3'b100, 0, "R4 repeated vco pulse fails");
        step(1, 0, 0, 3'b100, 0, "R2 vco-first gap one passes");
        step(1, 0, 0, 3'b100, 0, "R2 open pairing");
        step(1, 1, 0, 3'b100, 0, "R2 close and reopen same edge");
        step(0, 1, 0, 3'b100, 0, "R2 overlapping pairing closes");
        step(1, 1, 0, 3'b100, 1, "R2 both overlapping pairings counted");
        step(0, 0, 0, 3'b110, 1, "R7 last comparison passed");
        step(0, 0, 0, 3'b111, 1, "R7 lock with divided buffer");
        step(0, 0, 0, 3'b000, 0, "R7 forced low");
        step(0, 0, 0, 3'b011, 0, "R7 low with divided buffer");
        step(1, 1, 1, 3'b100, 1, "R5 standby pin high");
        step(0, 0, 1, 3'b000, 1, "R5 standby overrides select");
        step(0, 0, 0, 3'b001, 0, "R6 ref half cleared by standby");
        step(1, 0, 0, 3'b001, 1, "R6 ref half toggles");
        step(0, 1, 0, 3'b001, 1, "R6 ref half holds on vco");
        step(0, 0, 0, 3'b101, 1, "R6 vco half after one pulse");
        step(0, 1, 0, 3'b101, 0, "R6 vco half toggles back");
        step(1, 0, 0, 3'b101, 0, "R6 vco half holds on ref");
        step(1, 1, 0, 3'b100, 0, "R5 run cleared by standby");
        step(1, 1, 0, 3'b010, 1, "R7 registered ref pulse");
        step(0, 0, 0, 3'b010, 0, "R7 registered ref pulse ends");
        step(0, 0, 0, 3'b100, 1, "R3 lock held when idle");
        step(1, 0, 0, 3'b110, 1, "R7 test mode open pairing");
        step(0, 0, 0, 3'b110, 1, "R7 test mode waiting");
        step(0, 1, 0, 3'b110, 0, "R7 test mode shows failure");
        for (int i = 0; i < 12; i++) begin
            step(0, 0, 0, 3'b011, 0, "R8 divided reference");
        end
        step(0, 0, 0, 3'b111, 0, "R8 divided reference alternate code");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule